// File: doc/BRIEF.md
# Iterative Integer Multiply and Multiply-Add Unit

This block multiplies two 64-bit integer operands over several cycles and returns one 64-bit result. The same datapath covers every variant. It handles signed and unsigned products, full 64x64 or low-word 32x32 operands, a sign-extended 16-bit immediate as the second operand, and a three-operand multiply-add whose addend is extended to 128 bits. The result is taken from the low half of the 128-bit sum, the high half, or the upper 32 bits of a word product. For the two low-half forms that can overflow, an overflow flag is produced. The flag is set when the bits above the result are not all copies of the result's sign bit.

A one-cycle `start` pulse captures the opcode and the operands. The unit then stays busy while an iterative shift-and-add core takes `STEP` multiplier bits per cycle. When the result is ready, `done` is raised for exactly one cycle. The result and the flag then hold until the next operation completes. A `start` that arrives while the unit is busy is dropped.

Top module: `imul_unit`

## Requirements
- R1: Opcode 0 (low doubleword) returns bits 63:0 of the signed 128-bit product of `src_a` and `src_b`. `ovf` is 1 exactly when bits 127:63 of that product are not all equal. Opcodes 10 to 15 behave like opcode 0.
- R2: Opcode 3 (low word) multiplies the signed low 32 bits of each operand and returns the 64-bit product. `ovf` is 1 exactly when product bits 63:31 are not all equal.
- R3: Opcode 1 returns bits 127:64 of the signed 128-bit product. Opcode 2 returns bits 127:64 of the unsigned 128-bit product.
- R4: Opcode 4 (signed) and opcode 5 (unsigned) multiply the low 32 bits of each operand. Bits 63:32 of the 64-bit product are returned in `result[31:0]`. `result[63:32]` carries no defined value.
- R5: Opcode 6 multiplies `src_a` by `imm` sign-extended from 16 to 64 bits and returns bits 63:0 of the signed product.
- R6: Opcodes 7, 8 and 9 add `src_c` to the 128-bit product of `src_a` and `src_b`. Opcode 7 is signed, uses a sign-extended addend and returns sum bits 127:64. Opcode 8 is unsigned, uses a zero-extended addend and returns sum bits 127:64. Opcode 9 is signed, uses a sign-extended addend and returns sum bits 63:0.
- R7: Operands and opcode are captured on the `start` cycle. Changing them while the unit is busy does not affect the result. `result` and `ovf` change only in the cycle in which `done` is high.
- R8: `done` rises exactly 64/STEP+1 clock edges after the edge that samples `start`. It is high for one cycle, and `busy` is high from the accepting edge until the edge that raises `done`.
- R9: A `start` seen while `busy` is high is ignored: it causes no extra `done` and does not change the result.
- R10: After reset, `busy`, `done`, `ovf` and `result` are all 0.
- R11: `ovf` is 0 for every opcode other than 0, 3 and 10 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| op | input | 4 | Operation code (see requirements) |
| src_a | input | 64 | First multiplicand |
| src_b | input | 64 | Second multiplicand |
| src_c | input | 64 | Multiply-add addend |
| imm | input | 16 | Immediate for opcode 6 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| result | output | 64 | Selected result |
| ovf | output | 1 | Overflow flag of the overflow-capable forms |

## Verification
The checker verifies the handshake on every cycle. It confirms that `done` is a single-cycle pulse that only follows a busy period, that an accepted `start` raises `busy`, and that `busy` only drops with `done`. It also confirms that `result` never moves outside a `done` cycle and that `ovf` is only set for the overflow-capable opcodes. The arithmetic itself can only be shown by the bench's scenarios, which compare against a wide-integer model. Those scenarios cover the most-negative value, minus one, power-of-two overflow boundaries, garbage in the unused upper word bits, and negative addends under zero extension. The scenarios also cover exact latency, operand scrambling during busy, and a dropped `start`.

// File: rtl/imul_pkg.sv
package imul_pkg;

    typedef enum logic [3:0] {
        OP_MUL_LO_D   = 4'd0,
        OP_MUL_HI_D   = 4'd1,
        OP_MUL_HI_DU  = 4'd2,
        OP_MUL_LO_W   = 4'd3,
        OP_MUL_HI_W   = 4'd4,
        OP_MUL_HI_WU  = 4'd5,
        OP_MUL_IMM    = 4'd6,
        OP_MADD_HI    = 4'd7,
        OP_MADD_HI_U  = 4'd8,
        OP_MADD_LO    = 4'd9,
        OP_RSV_A      = 4'd10,
        OP_RSV_B      = 4'd11,
        OP_RSV_C      = 4'd12,
        OP_RSV_D      = 4'd13,
        OP_RSV_E      = 4'd14,
        OP_RSV_F      = 4'd15
    } imul_op_e;

    // which part of the 128-bit sum becomes the result
    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_HIW  = 2'd2
    } slice_e;

    // which overflow rule applies
    typedef enum logic [1:0] {
        OVK_NONE  = 2'd0,
        OVK_DWORD = 2'd1,
        OVK_WORD  = 2'd2
    } ovf_kind_e;

endpackage

// File: rtl/imul_operand_prep.sv
module imul_operand_prep
    import imul_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IMMW = 16
) (
    input  imul_op_e             op,
    input  logic [XLEN-1:0]      a,
    input  logic [XLEN-1:0]      b,
    input  logic [XLEN-1:0]      c,
    input  logic [IMMW-1:0]      imm,
    output logic [XLEN-1:0]      mag_a,
    output logic [XLEN-1:0]      mag_b,
    output logic                 neg,
    output logic [2*XLEN-1:0]    addend,
    output slice_e               slice,
    output ovf_kind_e            ovfk
);
    localparam int HW = XLEN / 2;

    logic [XLEN-1:0] ext_a, ext_b;
    logic            is_signed;
    logic            neg_a, neg_b;

    always_comb begin
        ext_a     = a;
        ext_b     = b;
        is_signed = 1'b1;
        addend    = '0;
        slice     = SEL_LO;
        ovfk      = OVK_NONE;
        case (op)
            OP_MUL_HI_D: begin
                slice = SEL_HI;
            end
            OP_MUL_HI_DU: begin
                slice     = SEL_HI;
                is_signed = 1'b0;
            end
            OP_MUL_LO_W: begin
                ext_a = {{HW{a[HW-1]}}, a[HW-1:0]};
                ext_b = {{HW{b[HW-1]}}, b[HW-1:0]};
                ovfk  = OVK_WORD;
            end
            OP_MUL_HI_W: begin
                ext_a = {{HW{a[HW-1]}}, a[HW-1:0]};
                ext_b = {{HW{b[HW-1]}}, b[HW-1:0]};
                slice = SEL_HIW;
            end
            OP_MUL_HI_WU: begin
                ext_a     = {{HW{1'b0}}, a[HW-1:0]};
                ext_b     = {{HW{1'b0}}, b[HW-1:0]};
                is_signed = 1'b0;
                slice     = SEL_HIW;
            end
            OP_MUL_IMM: begin
                ext_b = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
            end
            OP_MADD_HI: begin
                addend = {{XLEN{c[XLEN-1]}}, c};
                slice  = SEL_HI;
            end
            OP_MADD_HI_U: begin
                addend    = {{XLEN{1'b0}}, c};
                is_signed = 1'b0;
                slice     = SEL_HI;
            end
            OP_MADD_LO: begin
                addend = {{XLEN{c[XLEN-1]}}, c};
            end
            default: begin
                ovfk = OVK_DWORD;
            end
        endcase
        neg_a = is_signed & ext_a[XLEN-1];
        neg_b = is_signed & ext_b[XLEN-1];
        mag_a = neg_a ? (~ext_a + 1'b1) : ext_a;
        mag_b = neg_b ? (~ext_b + 1'b1) : ext_b;
        neg   = neg_a ^ neg_b;
    end

endmodule

// File: rtl/imul_iter_core.sv
module imul_iter_core #(
    parameter int XLEN = 64,
    parameter int STEP = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [XLEN-1:0]     a,
    input  logic [XLEN-1:0]     b,
    output logic [2*XLEN-1:0]   acc,
    output logic                fin
);
    localparam int NSTEP = XLEN / STEP;
    localparam int CW    = $clog2(NSTEP) + 1;
    localparam int PW    = 2 * XLEN;

    typedef struct packed {
        logic            running;
        logic            fin;
        logic [CW-1:0]   cnt;
        logic [PW-1:0]   acc;
        logic [PW-1:0]   mcand;
        logic [XLEN-1:0] mplier;
    } core_st_t;

    core_st_t st_d, st_q;

    // one partial product per multiplier bit in the current digit
    logic [PW-1:0] part [STEP];
    logic [PW-1:0] digit_sum;

    for (genvar g = 0; g < STEP; g++) begin : g_part
        assign part[g] = st_q.mplier[g] ? (st_q.mcand << g) : '0;
    end

    always_comb begin
        digit_sum = '0;
        for (int i = 0; i < STEP; i++) begin
            digit_sum = digit_sum + part[i];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        if (load) begin
            st_d.running = 1'b1;
            st_d.cnt     = '0;
            st_d.acc     = '0;
            st_d.mcand   = {{XLEN{1'b0}}, a};
            st_d.mplier  = b;
        end else if (st_q.running) begin
            st_d.acc    = st_q.acc + digit_sum;
            st_d.mcand  = st_q.mcand << STEP;
            st_d.mplier = st_q.mplier >> STEP;
            st_d.cnt    = st_q.cnt + 1'b1;
            if (st_q.cnt == CW'(NSTEP - 1)) begin
                st_d.running = 1'b0;
                st_d.fin     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;
    assign fin = st_q.fin;

endmodule

// File: rtl/imul_result_fmt.sv
module imul_result_fmt
    import imul_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [2*XLEN-1:0]  mag_prod,
    input  logic               neg,
    input  logic [2*XLEN-1:0]  addend,
    input  slice_e             slice,
    input  ovf_kind_e          ovfk,
    output logic [XLEN-1:0]    res,
    output logic               ovf
);
    localparam int HW = XLEN / 2;
    localparam int PW = 2 * XLEN;

    logic [PW-1:0]   prod;
    logic [PW-1:0]   sum;
    logic [XLEN:0]   top_d;
    logic [HW:0]     top_w;

    always_comb begin
        prod  = neg ? (~mag_prod + 1'b1) : mag_prod;
        sum   = prod + addend;
        top_d = sum[PW-1:XLEN-1];
        top_w = sum[XLEN-1:HW-1];
        case (slice)
            SEL_HI:  res = sum[PW-1:XLEN];
            SEL_HIW: res = {sum[XLEN-1:HW], sum[XLEN-1:HW]};
            default: res = sum[XLEN-1:0];
        endcase
        case (ovfk)
            OVK_DWORD: ovf = (|top_d) & ~(&top_d);
            OVK_WORD:  ovf = (|top_w) & ~(&top_w);
            default:   ovf = 1'b0;
        endcase
    end

endmodule

// File: rtl/imul_unit.sv
module imul_unit
    import imul_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IMMW = 16,
    parameter int STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic [XLEN-1:0]   src_c,
    input  logic [IMMW-1:0]   imm,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   result,
    output logic              ovf
);
    localparam int PW = 2 * XLEN;

    typedef struct packed {
        logic            busy;
        logic            done;
        imul_op_e        op;
        logic            neg;
        logic [PW-1:0]   addend;
        slice_e          slice;
        ovf_kind_e       ovfk;
        logic [XLEN-1:0] result;
        logic            ovf;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic [XLEN-1:0] p_mag_a, p_mag_b;
    logic            p_neg;
    logic [PW-1:0]   p_addend;
    slice_e          p_slice;
    ovf_kind_e       p_ovfk;
    logic            accept;
    logic [PW-1:0]   core_acc;
    logic            core_fin;
    logic [XLEN-1:0] f_res;
    logic            f_ovf;
    imul_op_e        op_lat;

    imul_operand_prep #(.XLEN(XLEN), .IMMW(IMMW)) u_prep (
        .op     (imul_op_e'(op)),
        .a      (src_a),
        .b      (src_b),
        .c      (src_c),
        .imm    (imm),
        .mag_a  (p_mag_a),
        .mag_b  (p_mag_b),
        .neg    (p_neg),
        .addend (p_addend),
        .slice  (p_slice),
        .ovfk   (p_ovfk)
    );

    imul_iter_core #(.XLEN(XLEN), .STEP(STEP)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .a     (p_mag_a),
        .b     (p_mag_b),
        .acc   (core_acc),
        .fin   (core_fin)
    );

    imul_result_fmt #(.XLEN(XLEN)) u_fmt (
        .mag_prod (core_acc),
        .neg      (st_q.neg),
        .addend   (st_q.addend),
        .slice    (st_q.slice),
        .ovfk     (st_q.ovfk),
        .res      (f_res),
        .ovf      (f_ovf)
    );

    assign accept = start & ~st_q.busy;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.busy   = 1'b1;
            st_d.op     = imul_op_e'(op);
            st_d.neg    = p_neg;
            st_d.addend = p_addend;
            st_d.slice  = p_slice;
            st_d.ovfk   = p_ovfk;
        end
        if (core_fin) begin
            st_d.busy   = 1'b0;
            st_d.done   = 1'b1;
            st_d.result = f_res;
            st_d.ovf    = f_ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, done: 1'b0, op: OP_MUL_LO_D, neg: 1'b0,
                      addend: '0, slice: SEL_LO, ovfk: OVK_NONE,
                      result: '0, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign result = st_q.result;
    assign ovf    = st_q.ovf;
    assign op_lat = st_q.op;

endmodule

// File: rtl/imul_unit_chk.sv
module imul_unit_chk
    import imul_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            busy,
    input  logic            done,
    input  logic [XLEN-1:0] result,
    input  logic            ovf,
    input  imul_op_e        op_lat
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(ovf)));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (op_lat == OP_MUL_LO_D || op_lat == OP_MUL_LO_W ||
                           op_lat >= OP_RSV_A));

endmodule

bind imul_unit imul_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .ovf    (ovf),
    .op_lat (op_lat)
);

// File: tb/sim_imul_unit.sv
`timescale 1ns/1ps
module sim_imul_unit;

    localparam int LAT = 64 / 2 + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [63:0] src_a = '0, src_b = '0, src_c = '0;
    logic [15:0] imm = '0;
    logic        busy, done, ovf;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    imul_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .src_c(src_c), .imm(imm),
        .busy(busy), .done(done), .result(result), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] sx64(input logic [63:0] v);
        return {{64{v[63]}}, v};
    endfunction

    function automatic logic [127:0] sx32(input logic [31:0] v);
        return {{96{v[31]}}, v};
    endfunction

    // wide-integer reference; hiw set when only result[31:0] is defined
    task automatic ref_model(input logic [3:0] o, input logic [63:0] a, b, c,
                             input logic [15:0] im, output logic [63:0] r,
                             output logic ov, output bit hiw);
        logic [127:0] xa, xb, xc, s;
        hiw = 0; ov = 0; xc = '0;
        case (o)
            4'd1, 4'd7, 4'd9: begin xa = sx64(a); xb = sx64(b); end
            4'd2, 4'd8: begin xa = {64'd0, a}; xb = {64'd0, b}; end
            4'd3, 4'd4: begin xa = sx32(a[31:0]); xb = sx32(b[31:0]); end
            4'd5: begin xa = {96'd0, a[31:0]}; xb = {96'd0, b[31:0]}; end
            4'd6: begin xa = sx64(a); xb = {{112{im[15]}}, im}; end
            default: begin xa = sx64(a); xb = sx64(b); end
        endcase
        if (o == 4'd7 || o == 4'd9) xc = sx64(c);
        if (o == 4'd8) xc = {64'd0, c};
        s = xa * xb + xc;
        case (o)
            4'd1, 4'd2, 4'd7, 4'd8: r = s[127:64];
            4'd4, 4'd5: begin r = {32'd0, s[63:32]}; hiw = 1; end
            4'd3: begin r = s[63:0]; ov = !(s[63:31] == '0 || s[63:31] == '1); end
            4'd6, 4'd9: r = s[63:0];
            default: begin r = s[63:0]; ov = !(s[127:63] == '0 || s[127:63] == '1); end
        endcase
    endtask

    // mode 0 plain, 1 scramble inputs while busy, 2 extra start while busy
    task automatic run_op(input logic [3:0] o, input logic [63:0] a, b, c,
                          input logic [15:0] im, input int mode, input string req);
        logic [63:0] er; logic eo; bit hiw; int cyc;
        ref_model(o, a, b, c, im, er, eo, hiw);
        @(negedge clk);
        op = o; src_a = a; src_b = b; src_c = c; imm = im; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (mode == 1) begin
                op = 4'($urandom); src_a = {$urandom, $urandom};
                src_b = {$urandom, $urandom}; src_c = {$urandom, $urandom};
                imm = 16'($urandom);
            end
            if (mode == 2 && cyc == 3) begin
                op = 4'd2; src_a = '1; src_b = '1; start = 1'b1;
            end
            if (mode == 2 && cyc == 4) start = 1'b0;
            if (done || cyc > 200) break;
        end
        chk(done, {req, " done seen"}, 64'(done), 64'd1);
        chk(cyc == LAT, "R8 latency", 64'(cyc), 64'(LAT));
        if (hiw) chk(result[31:0] == er[31:0], req, {32'd0, result[31:0]}, er);
        else     chk(result == er, req, result, er);
        chk(ovf == eo, {req, " ovf"}, 64'(ovf), 64'(eo));
        start = 1'b0;
        if (mode == 2) begin
            for (int k = 0; k < LAT + 4; k++) begin
                @(negedge clk);
                chk(!done, "R9 no extra done", 64'(done), 64'd0);
            end
            chk(result == er, "R9 result kept", result, er);
        end
    endtask

    task automatic t_reset();
        chk(busy == 0 && done == 0, "R10 busy/done", {62'd0, busy, done}, 64'd0);
        chk(result == 0 && ovf == 0, "R10 result/ovf", result, 64'd0);
    endtask

    task automatic t_lo_d();
        run_op(0, 64'h8000_0000_0000_0000, '1, 0, 0, 0, "R1 min*-1");
        run_op(0, '1, '1, 0, 0, 0, "R1 -1*-1");
        run_op(0, 64'h1_0000_0000, 64'h8000_0000, 0, 0, 0, "R1 2^63");
        run_op(0, 64'h1_0000_0000, 64'h4000_0000, 0, 0, 0, "R1 2^62");
        run_op(0, 64'h1_0000_0000, 64'hFFFF_FFFF_8000_0000, 0, 0, 0, "R1 -2^63");
        run_op(12, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 0, 0, 0, "R1 code12");
        for (int i = 0; i < 6; i++)
            run_op(0, {$urandom, $urandom}, {$urandom, $urandom}, 0, 0, 0, "R1 random");
    endtask

    task automatic t_lo_w();
        run_op(3, 64'hDEAD_BEEF_8000_0000, 64'h1234_5678_FFFF_FFFF, 0, 0, 0, "R2 min*-1");
        run_op(3, 64'hFFFF_0000_0000_FFFF, 64'h0000_FFFF_0000_7FFF, 0, 0, 0, "R2 no ovf");
        for (int i = 0; i < 4; i++)
            run_op(3, {$urandom, $urandom}, {$urandom, $urandom}, 0, 0, 0, "R2 random");
    endtask

    task automatic t_hi_d();
        run_op(1, '1, '1, 0, 0, 0, "R3 signed -1*-1");
        run_op(2, '1, '1, 0, 0, 0, "R3 unsigned -1*-1");
        run_op(1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 0, 0, "R3 min*min");
        run_op(2, 64'h8000_0000_0000_0000, 64'h3, 0, 0, 0, "R3 unsigned 2^63*3");
        for (int i = 0; i < 3; i++) begin
            run_op(1, {$urandom, $urandom}, {$urandom, $urandom}, 0, 0, 0, "R3 random s");
            run_op(2, {$urandom, $urandom}, {$urandom, $urandom}, 0, 0, 0, "R3 random u");
        end
    endtask

    task automatic t_hi_w();
        run_op(4, 64'h0000_0001_FFFF_FFFF, 64'h7777_0000_FFFF_FFFF, 0, 0, 0, "R4 signed -1*-1");
        run_op(5, 64'h0000_0001_FFFF_FFFF, 64'h7777_0000_FFFF_FFFF, 0, 0, 0, "R4 unsigned");
        run_op(4, 64'h8000_0000, 64'h8000_0000, 0, 0, 0, "R4 min*min");
        run_op(5, {$urandom, $urandom}, {$urandom, $urandom}, 0, 0, 0, "R4 random u");
    endtask

    task automatic t_imm();
        run_op(6, 64'd1000, 64'hFFFF, 0, 16'h8000, 0, "R5 imm -32768");
        run_op(6, '1, 0, 0, 16'h7FFF, 0, "R5 -1*32767");
        run_op(6, 64'h4000_0000_0000_0000, 0, 0, 16'h0004, 0, "R5 wrap no ovf");
    endtask

    task automatic t_madd();
        run_op(7, '1, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R6 hi signed neg addend");
        run_op(8, '1, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R6 hi unsigned zext addend");
        run_op(9, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, 64'h8000_0000_0000_0000, 0, 0, "R6 lo");
        for (int i = 0; i < 2; i++) begin
            run_op(7, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 0, 0, "R6 rnd 7");
            run_op(8, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 0, 0, "R6 rnd 8");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lo_d();
        t_lo_w();
        t_hi_d();
        t_hi_w();
        t_imm();
        t_madd();
        run_op(0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 0, 0, 1, "R7 latch");
        run_op(3, 64'h7FFF_FFFF, 64'h7FFF_FFFF, 0, 0, 1, "R7 latch word");
        run_op(1, 64'd5, 64'd9, 0, 0, 2, "R9 start while busy");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule